// File: doc/BRIEF.md
# Processor Mode State Register

This block keeps a registered copy of the execution-mode status word that the instruction front end consults on every fetch. The word is not stored as written data. It is rebuilt from a small set of source fields: the long-mode-active bit, the CR0 protection and paging bits, the code-segment attributes (long-mode, default-size and DPL), the stack-segment default-size bit and the flags VM bit. The block keeps its own copy of every source field. Each field is refreshed by its own write strobe.

The word is rebuilt only when a source that affects it is written: CR0, the code-segment attributes or the stack-segment attributes. It is also rebuilt when software writes the status word itself, and when a restore pulse arrives after a checkpoint load. Between those events the word holds its value. A rebuild always uses the value being written in the same cycle, never the older copy. The rebuilt word appears at the clock edge that samples the strobe.

There is no state machine. The only sequential behaviour is "hold" or "refresh" on each edge.

Top module: `pms_mode_reg`

## Requirements
- R1: After reset every output is zero (mode legacy, submode real, all size codes 0) and every source copy is zero.
- R2: With long-mode-active set, mode_o is 1. submode_o is 4 (64-bit) when the code-segment long attribute is set and 3 (compatibility) otherwise.
- R3: With long-mode-active clear, mode_o is 0. submode_o is 0 (real) when CR0 protection is clear. When protection is set it is 2 (virtual-8086) if the flags VM bit is set and 1 (protected) otherwise.
- R4: cpl_o equals the code-segment DPL, paging_o equals the CR0 paging bit and prot_o equals the CR0 protection bit.
- R5: The operand size codes (default, alternate) are (2,1) in submode 4 or when the code-segment default-size bit is set, and (1,2) otherwise.
- R6: The address size codes (default, alternate) are (3,2) in submode 4, (2,1) when the code-segment default-size bit is set, and (1,2) otherwise.
- R7: The stack size code is 3 in submode 4, 2 when the stack-segment default-size bit is set, and 1 otherwise.
- R8: A strobe on cr0_we, cs_we or ss_we rebuilds the word at that clock edge. The rebuild uses the input values presented with every strobe active in that cycle.
- R9: Strobes on efer_we or flg_we only update the source copy. The outputs keep their value until a later rebuild, and no output changes in a cycle without a rebuild strobe.
- R10: A strobe on word_we or restore_pulse rebuilds the word from the current source copies. The rebuild also takes in any source strobed in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| efer_we | input | 1 | Write strobe for the long-mode-active bit |
| efer_lma_in | input | 1 | Long-mode-active value |
| cr0_we | input | 1 | Write strobe for the CR0 bits |
| cr0_pe_in | input | 1 | Protection enable value |
| cr0_pg_in | input | 1 | Paging enable value |
| cs_we | input | 1 | Write strobe for the code-segment attributes |
| cs_long_in | input | 1 | Code-segment long-mode attribute |
| cs_dsize_in | input | 1 | Code-segment default-size attribute |
| cs_dpl_in | input | 2 | Code-segment DPL |
| ss_we | input | 1 | Write strobe for the stack-segment attribute |
| ss_dsize_in | input | 1 | Stack-segment default-size attribute |
| flg_we | input | 1 | Write strobe for the flags VM bit |
| flg_vm_in | input | 1 | Virtual-8086 flag value |
| word_we | input | 1 | Write to the status word; carries no data and forces a rebuild |
| restore_pulse | input | 1 | Rebuild after a checkpoint restore |
| mode_o | output | 1 | 0 legacy, 1 long |
| submode_o | output | 3 | 0 real, 1 protected, 2 virtual-8086, 3 compatibility, 4 64-bit |
| cpl_o | output | 2 | Current privilege level |
| paging_o | output | 1 | Paging enabled |
| prot_o | output | 1 | Protection enabled |
| op_def_o | output | 2 | Default operand size code |
| op_alt_o | output | 2 | Alternate operand size code |
| addr_def_o | output | 2 | Default address size code |
| addr_alt_o | output | 2 | Alternate address size code |
| stack_o | output | 2 | Stack size code |

## Verification
A wrong source copy stays hidden until the next rebuild strobe. The reference model therefore uses efer and flags writes that are later followed by a code-segment, stack-segment, word or restore strobe. A stale copy then shows up as a wrong submode or size code one edge after that strobe. A rebuild that used the old value instead of the value being written shows on the edge that samples the strobe. A word that refreshes when it should hold shows on the first edge after an efer or flags-only write. The model compares every output field on every clock, so each of these faults surfaces within one cycle of the event that exposes it.

// File: rtl/pms_pkg.sv
package pms_pkg;
    localparam int DPL_W  = 2;
    localparam int SIZE_W = 2;
    localparam int SUB_W  = 3;

    typedef enum logic [SUB_W-1:0] {
        SUB_REAL   = 3'd0,
        SUB_PROT   = 3'd1,
        SUB_V86    = 3'd2,
        SUB_COMPAT = 3'd3,
        SUB_64     = 3'd4
    } submode_e;

    // Source fields the status word is derived from
    typedef struct packed {
        logic             lma;
        logic             pe;
        logic             pg;
        logic             cs_long;
        logic             cs_dsize;
        logic [DPL_W-1:0] cs_dpl;
        logic             ss_dsize;
        logic             vm;
    } src_t;

    typedef struct packed {
        logic              mode;
        submode_e          sub;
        logic [DPL_W-1:0]  cpl;
        logic              paging;
        logic              prot;
        logic [SIZE_W-1:0] op_def;
        logic [SIZE_W-1:0] op_alt;
        logic [SIZE_W-1:0] addr_def;
        logic [SIZE_W-1:0] addr_alt;
        logic [SIZE_W-1:0] stack;
    } word_t;

    localparam int WORD_W = $bits(word_t);
endpackage

// File: rtl/pms_src_shadow.sv
module pms_src_shadow
    import pms_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic efer_we,
    input  logic cr0_we,
    input  logic cs_we,
    input  logic ss_we,
    input  logic flg_we,
    input  src_t wr_val,
    output src_t cur_q,
    output src_t merged
);
    // Same-cycle writes take precedence over the stored copy
    always_comb begin
        merged          = cur_q;
        if (efer_we) merged.lma = wr_val.lma;
        if (cr0_we) begin
            merged.pe = wr_val.pe;
            merged.pg = wr_val.pg;
        end
        if (cs_we) begin
            merged.cs_long  = wr_val.cs_long;
            merged.cs_dsize = wr_val.cs_dsize;
            merged.cs_dpl   = wr_val.cs_dpl;
        end
        if (ss_we)  merged.ss_dsize = wr_val.ss_dsize;
        if (flg_we) merged.vm       = wr_val.vm;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= merged;
    end
endmodule

// File: rtl/pms_decode.sv
module pms_decode
    import pms_pkg::*;
(
    input  src_t  src,
    output word_t word
);
    submode_e sub;

    always_comb begin
        if (src.lma)     sub = src.cs_long ? SUB_64 : SUB_COMPAT;
        else if (src.pe) sub = src.vm ? SUB_V86 : SUB_PROT;
        else             sub = SUB_REAL;
    end

    always_comb begin
        word        = '0;
        word.mode   = src.lma;
        word.sub    = sub;
        word.cpl    = src.cs_dpl;
        word.paging = src.pg;
        word.prot   = src.pe;

        if (sub == SUB_64 || src.cs_dsize) begin
            word.op_def = SIZE_W'(2);
            word.op_alt = SIZE_W'(1);
        end else begin
            word.op_def = SIZE_W'(1);
            word.op_alt = SIZE_W'(2);
        end

        unique case (1'b1)
            (sub == SUB_64): begin
                word.addr_def = SIZE_W'(3);
                word.addr_alt = SIZE_W'(2);
            end
            (sub != SUB_64 && src.cs_dsize): begin
                word.addr_def = SIZE_W'(2);
                word.addr_alt = SIZE_W'(1);
            end
            default: begin
                word.addr_def = SIZE_W'(1);
                word.addr_alt = SIZE_W'(2);
            end
        endcase

        if (sub == SUB_64)     word.stack = SIZE_W'(3);
        else if (src.ss_dsize) word.stack = SIZE_W'(2);
        else                   word.stack = SIZE_W'(1);
    end
endmodule

// File: rtl/pms_mode_reg.sv
module pms_mode_reg
    import pms_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  efer_we,
    input  logic                  efer_lma_in,
    input  logic                  cr0_we,
    input  logic                  cr0_pe_in,
    input  logic                  cr0_pg_in,
    input  logic                  cs_we,
    input  logic                  cs_long_in,
    input  logic                  cs_dsize_in,
    input  logic [DPL_W-1:0]      cs_dpl_in,
    input  logic                  ss_we,
    input  logic                  ss_dsize_in,
    input  logic                  flg_we,
    input  logic                  flg_vm_in,
    input  logic                  word_we,
    input  logic                  restore_pulse,
    output logic                  mode_o,
    output logic [SUB_W-1:0]      submode_o,
    output logic [DPL_W-1:0]      cpl_o,
    output logic                  paging_o,
    output logic                  prot_o,
    output logic [SIZE_W-1:0]     op_def_o,
    output logic [SIZE_W-1:0]     op_alt_o,
    output logic [SIZE_W-1:0]     addr_def_o,
    output logic [SIZE_W-1:0]     addr_alt_o,
    output logic [SIZE_W-1:0]     stack_o
);
    src_t  wr_val, cur_q, merged;
    word_t derived, word_q;
    logic  rebuild;

    always_comb begin
        wr_val.lma      = efer_lma_in;
        wr_val.pe       = cr0_pe_in;
        wr_val.pg       = cr0_pg_in;
        wr_val.cs_long  = cs_long_in;
        wr_val.cs_dsize = cs_dsize_in;
        wr_val.cs_dpl   = cs_dpl_in;
        wr_val.ss_dsize = ss_dsize_in;
        wr_val.vm       = flg_vm_in;
    end

    pms_src_shadow u_shadow (
        .clk     (clk),
        .rst_n   (rst_n),
        .efer_we (efer_we),
        .cr0_we  (cr0_we),
        .cs_we   (cs_we),
        .ss_we   (ss_we),
        .flg_we  (flg_we),
        .wr_val  (wr_val),
        .cur_q   (cur_q),
        .merged  (merged)
    );

    pms_decode u_decode (
        .src  (merged),
        .word (derived)
    );

    // Efer and flags writes are deliberately absent from the rebuild set
    assign rebuild = cr0_we | cs_we | ss_we | word_we | restore_pulse;

    always_ff @(posedge clk) begin
        if (!rst_n)       word_q <= '0;
        else if (rebuild) word_q <= derived;
    end

    always_comb begin
        mode_o     = word_q.mode;
        submode_o  = word_q.sub;
        cpl_o      = word_q.cpl;
        paging_o   = word_q.paging;
        prot_o     = word_q.prot;
        op_def_o   = word_q.op_def;
        op_alt_o   = word_q.op_alt;
        addr_def_o = word_q.addr_def;
        addr_alt_o = word_q.addr_alt;
        stack_o    = word_q.stack;
    end

    AST_LONG_SUBMODE: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o |-> (submode_o == 3'd3 || submode_o == 3'd4)); // R2
    AST_LEGACY_SUBMODE: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_o |-> (submode_o <= 3'd2)); // R3
    AST_CPL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        cs_we |=> (cpl_o == $past(cs_dpl_in))); // R4
    AST_PAGING_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        cr0_we |=> (paging_o == $past(cr0_pg_in) && prot_o == $past(cr0_pe_in))); // R8
    AST_WIDE_CODES: assert property (@(posedge clk) disable iff (!rst_n)
        (submode_o == 3'd4) |-> (stack_o == 2'd3 && addr_def_o == 2'd3 && op_def_o == 2'd2)); // R7
    AST_HOLD_NO_REBUILD: assert property (@(posedge clk) disable iff (!rst_n)
        !(cr0_we || cs_we || ss_we || word_we || restore_pulse)
        |=> ($stable(submode_o) && $stable(mode_o) && $stable(stack_o) && $stable(cpl_o))); // R9
endmodule

// File: tb/test_pms_mode_reg.sv
module test_pms_mode_reg;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic efer_we = 0, efer_lma_in = 0, cr0_we = 0, cr0_pe_in = 0, cr0_pg_in = 0;
    logic cs_we = 0, cs_long_in = 0, cs_dsize_in = 0;
    logic [1:0] cs_dpl_in = 0;
    logic ss_we = 0, ss_dsize_in = 0, flg_we = 0, flg_vm_in = 0, word_we = 0, restore_pulse = 0;
    logic mode_o, paging_o, prot_o;
    logic [2:0] submode_o;
    logic [1:0] cpl_o, op_def_o, op_alt_o, addr_def_o, addr_alt_o, stack_o;

    pms_mode_reg i_pms_mode_reg (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_vec = 0, n_bad = 0;
    bit done = 0;

    // Reference state
    int s_lma, s_pe, s_pg, s_csl, s_csd, s_dpl, s_ssd, s_vm;
    int e_mode, e_sub, e_cpl, e_pg, e_pe, e_opd, e_opa, e_ad, e_aa, e_st;

    task automatic model_reset();
        s_lma = 0; s_pe = 0; s_pg = 0; s_csl = 0; s_csd = 0; s_dpl = 0; s_ssd = 0; s_vm = 0;
        e_mode = 0; e_sub = 0; e_cpl = 0; e_pg = 0; e_pe = 0;
        e_opd = 0; e_opa = 0; e_ad = 0; e_aa = 0; e_st = 0;
    endtask

    task automatic model_edge();
        if (efer_we) s_lma = efer_lma_in;
        if (cr0_we) begin s_pe = cr0_pe_in; s_pg = cr0_pg_in; end
        if (cs_we) begin s_csl = cs_long_in; s_csd = cs_dsize_in; s_dpl = cs_dpl_in; end
        if (ss_we) s_ssd = ss_dsize_in;
        if (flg_we) s_vm = flg_vm_in;
        if (cr0_we || cs_we || ss_we || word_we || restore_pulse) begin
            bit wide;
            e_mode = s_lma;
            if (s_lma != 0) e_sub = (s_csl != 0) ? 4 : 3;
            else if (s_pe == 0) e_sub = 0;
            else e_sub = (s_vm != 0) ? 2 : 1;
            wide = (e_sub == 4);
            e_cpl = s_dpl; e_pg = s_pg; e_pe = s_pe;
            if (wide || s_csd != 0) begin e_opd = 2; e_opa = 1; end
            else begin e_opd = 1; e_opa = 2; end
            if (wide) begin e_ad = 3; e_aa = 2; end
            else if (s_csd != 0) begin e_ad = 2; e_aa = 1; end
            else begin e_ad = 1; e_aa = 2; end
            e_st = wide ? 3 : (s_ssd != 0 ? 2 : 1);
        end
    endtask

    task automatic cmp(string tag, string what, int got, int exp);
        n_vec++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s got %0d expected %0d at %0t", tag, what, got, exp, $time);
        end
    endtask

    task automatic compare_all();
        string mtag;
        mtag = (e_mode != 0) ? "R2" : "R3";
        cmp(mtag, "mode", mode_o, e_mode);
        cmp(mtag, "submode", submode_o, e_sub);
        cmp("R4", "cpl", cpl_o, e_cpl);
        cmp("R4", "paging", paging_o, e_pg);
        cmp("R4", "prot", prot_o, e_pe);
        cmp("R5", "op_def", op_def_o, e_opd);
        cmp("R5", "op_alt", op_alt_o, e_opa);
        cmp("R6", "addr_def", addr_def_o, e_ad);
        cmp("R6", "addr_alt", addr_alt_o, e_aa);
        cmp("R7", "stack", stack_o, e_st);
    endtask

    task automatic clear_strobes();
        efer_we = 0; cr0_we = 0; cs_we = 0; ss_we = 0; flg_we = 0; word_we = 0; restore_pulse = 0;
    endtask

    // One cycle: inputs set at negedge, model steps at posedge, compare at next negedge
    task automatic tick();
        @(posedge clk);
        if (rst_n) model_edge(); else model_reset();
        @(negedge clk);
        compare_all();
        clear_strobes();
    endtask

    task automatic wr_cs(bit l, bit d, int p);
        cs_we = 1; cs_long_in = l; cs_dsize_in = d; cs_dpl_in = 2'(p); tick();
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        model_reset();
        @(negedge clk);
        tick(); tick();
        // R1: reset state is all zero
        compare_all();
        rst_n = 1;
        tick();

        // R9: efer write alone leaves the word untouched
        efer_we = 1; efer_lma_in = 1; tick();
        tick();
        // R8: code-segment write rebuilds with its new value -> 64-bit (R2)
        wr_cs(1, 0, 3);
        // R2: compatibility
        wr_cs(0, 1, 0);
        // R7: stack-size via ss write
        ss_we = 1; ss_dsize_in = 1; tick();
        // R3: leave long mode, real
        efer_we = 1; efer_lma_in = 0; tick();
        // R10: status-word write rebuilds from current copies
        word_we = 1; tick();
        // R8: CR0 protect + paging, same-cycle new values
        cr0_we = 1; cr0_pe_in = 1; cr0_pg_in = 1; tick();
        // R9: flags VM write is held until a rebuild
        flg_we = 1; flg_vm_in = 1; tick();
        tick();
        // R10: restore pulse picks up the VM copy -> virtual-8086
        restore_pulse = 1; tick();
        // R5/R6: legacy default-size off
        wr_cs(0, 0, 1);
        // R8: simultaneous efer + cs writes both taken
        efer_we = 1; efer_lma_in = 1; cs_we = 1; cs_long_in = 1; cs_dsize_in = 0; cs_dpl_in = 2; tick();

        // Random traffic
        for (int i = 0; i < 3000; i++) begin
            efer_we = ($urandom_range(0, 5) == 0); efer_lma_in = 1'($urandom);
            cr0_we = ($urandom_range(0, 5) == 0); cr0_pe_in = 1'($urandom); cr0_pg_in = 1'($urandom);
            cs_we = ($urandom_range(0, 5) == 0); cs_long_in = 1'($urandom);
            cs_dsize_in = 1'($urandom); cs_dpl_in = 2'($urandom);
            ss_we = ($urandom_range(0, 6) == 0); ss_dsize_in = 1'($urandom);
            flg_we = ($urandom_range(0, 5) == 0); flg_vm_in = 1'($urandom);
            word_we = ($urandom_range(0, 9) == 0);
            restore_pulse = ($urandom_range(0, 11) == 0);
            tick();
        end

        // R1: reset again mid-run clears the word
        rst_n = 0; tick();
        compare_all();
        rst_n = 1; tick();
        summary();
    end
endmodule